// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division and keeps the outcome in two dedicated result registers, HI and LO. A host issues one operation at a time by pulsing a start strobe together with a 3-bit operation code and two operands. Products are built by a shift-add loop and quotients by a restoring divider, both running one bit per clock, so an arithmetic operation occupies the unit for a fixed number of cycles while the busy flag is high.

Signed variants work on the magnitudes of the operands and fix the signs of the results in the same cycle that HI and LO are written. Two move operations load HI or LO directly from the first operand without any arithmetic and without making the unit busy. A divide with a zero divisor runs its full length but leaves HI and LO as they were.

Top module: `md_unit`

## Requirements
- R1: After a synchronous reset, HI and LO read zero and busy is low.
- R2: Operation code 1 (unsigned multiply) forms the 64-bit product of the zero-extended operands A and B; bits 31:0 go to LO and bits 63:32 go to HI.
- R3: Operation code 0 (signed multiply) forms the 64-bit product of the sign-extended operands A and B, split between HI and LO as in R2.
- R4: Operation code 3 (unsigned divide) writes A divided by B to LO and the remainder to HI.
- R5: Operation code 2 (signed divide) treats A and B as two's complement, truncates the quotient toward zero into LO and writes a remainder carrying the sign of A into HI.
- R6: A divide (code 2 or 3) with B equal to zero leaves both HI and LO unchanged.
- R7: Operation code 4 copies A into HI and code 5 copies A into LO on the clock edge that samples start; the other register keeps its value and busy stays low.
- R8: For codes 0 to 3, busy is high from the cycle after start for exactly 32 cycles; HI and LO hold the result on the first cycle busy is low again.
- R9: While busy is high, HI and LO keep their previous values, and a start arriving then is ignored.
- R10: The signed divide of 0x80000000 by 0xFFFFFFFF yields LO = 0x80000000 and HI = 0.
- R11: Operation codes 6 and 7 have no effect on HI, LO or busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe, sampled when busy is low |
| op | input | 3 | Operation code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 set HI, 5 set LO) |
| opa | input | 32 | Operand A: multiplicand, dividend or move source |
| opb | input | 32 | Operand B: multiplier or divisor |
| hi | output | 32 | HI result register |
| lo | output | 32 | LO result register |
| busy | output | 1 | High while a multiply or divide is iterating |

## Verification
The embedded properties watch, on every cycle, that busy lasts a fixed run once raised, that HI and LO hold still through that run and after a zero-divisor divide, that a move lands in the selected register alone, and that the partial remainder stays below the divisor. The numerical correctness of products, quotients and remainders, including sign handling at the most negative value, can only be shown by the bench comparing finished results against its own arithmetic across directed corners and random operand mixes. The bench also shows that a start issued mid-operation does not disturb the running result.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [2:0] {
        MD_MULS  = 3'd0,
        MD_MULU  = 3'd1,
        MD_DIVS  = 3'd2,
        MD_DIVU  = 3'd3,
        MD_SETHI = 3'd4,
        MD_SETLO = 3'd5
    } md_op_e;

    typedef enum logic {
        K_MUL = 1'b0,
        K_DIV = 1'b1
    } md_kind_e;

    // Job descriptor latched at issue and held for the whole run
    typedef struct packed {
        md_kind_e kind;
        logic     neg_lo;    // negate low result (product or quotient)
        logic     neg_hi;    // negate remainder (div only)
        logic     zero_div;  // divisor was zero: suppress write-back
    } md_job_t;

    function automatic logic op_is_arith(input logic [2:0] code);
        return code[2] == 1'b0;
    endfunction

    function automatic logic op_is_div(input logic [2:0] code);
        return (code == MD_DIVS) || (code == MD_DIVU);
    endfunction

    function automatic logic op_is_signed(input logic [2:0] code);
        return (code == MD_MULS) || (code == MD_DIVS);
    endfunction

endpackage

// File: rtl/md_seq.sv
module md_seq
    import md_pkg::*;
#(
    parameter int ITER = 32
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    input  md_job_t job_in,
    output logic    busy,
    output logic    last,
    output md_job_t job
);
    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(ITER - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    md_job_t       job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            job_q  <= '0;
        end else if (go && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            job_q  <= job_in;
        end else if (busy_q) begin
            if (cnt_q == CNT_END) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (cnt_q == CNT_END);
    assign job  = job_q;

    // R8: an accepted start raises busy with a fresh count
    p_go_raises_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (go && !busy_q) |=> (busy_q && cnt_q == '0));

    // R8: busy persists until the final iteration, then drops
    p_busy_run_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != CNT_END) |=> busy_q);

    p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == CNT_END && !go) |=> !busy_q);

endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod_next
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] acc_q;
    logic [W:0]     upper;
    logic [2*W-1:0] acc_n;

    // One shift-add iteration: add multiplicand into the upper half when the
    // current multiplier bit is set, then shift the whole accumulator right.
    always_comb begin
        upper = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
        acc_n = {upper, acc_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc_q   <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            acc_q <= acc_n;
        end
    end

    assign prod_next = acc_n;

    // R2: multiplicand is frozen during iteration
    p_mcand_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(mcand_q));

endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_in,
    input  logic [W-1:0] divisor_in,
    output logic [W-1:0] quo_next,
    output logic [W-1:0] rem_next
);
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         fits;

    // Restoring step: bring down the next dividend bit, trial-subtract,
    // keep the difference only when it did not go negative.
    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        diff     = shifted - {1'b0, dvs_q};
        fits     = !diff[W];
        rem_next = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_next = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend_in;
            dvs_q <= divisor_in;
        end else if (step) begin
            rem_q <= rem_next;
            quo_q <= quo_next;
        end
    end

    // R4: the partial remainder never reaches the divisor
    p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && dvs_q != '0) |=> (rem_q < dvs_q));

endmodule

// File: rtl/md_unit.sv
module md_unit
    import md_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo,
    output logic            busy
);
    localparam int ITER = XLEN;
    localparam int PW   = 2 * XLEN;

    logic            busy_w;
    logic            last_w;
    logic            accept;
    logic            go_arith;
    logic            sgn;
    logic            a_neg;
    logic            b_neg;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    md_job_t         job_new;
    md_job_t         job_cur;

    logic [PW-1:0]   prod_raw;
    logic [PW-1:0]   prod_fix;
    logic [XLEN-1:0] quo_raw;
    logic [XLEN-1:0] rem_raw;
    logic [XLEN-1:0] quo_fix;
    logic [XLEN-1:0] rem_fix;

    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;

    // Issue decode and operand conditioning
    always_comb begin
        accept   = start && !busy_w;
        go_arith = accept && op_is_arith(op);
        sgn      = op_is_signed(op);
        a_neg    = sgn && opa[XLEN-1];
        b_neg    = sgn && opb[XLEN-1];
        mag_a    = a_neg ? (~opa + 1'b1) : opa;
        mag_b    = b_neg ? (~opb + 1'b1) : opb;
        job_new.kind     = op_is_div(op) ? K_DIV : K_MUL;
        job_new.neg_lo   = a_neg ^ b_neg;
        job_new.neg_hi   = op_is_div(op) ? a_neg : (a_neg ^ b_neg);
        job_new.zero_div = op_is_div(op) && (opb == '0);
    end

    md_seq #(.ITER(ITER)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go_arith),
        .job_in (job_new),
        .busy   (busy_w),
        .last   (last_w),
        .job    (job_cur)
    );

    md_mul_core #(.W(XLEN)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .load      (go_arith),
        .step      (busy_w),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .prod_next (prod_raw)
    );

    md_div_core #(.W(XLEN)) u_div (
        .clk         (clk),
        .rst         (rst),
        .load        (go_arith),
        .step        (busy_w),
        .dividend_in (mag_a),
        .divisor_in  (mag_b),
        .quo_next    (quo_raw),
        .rem_next    (rem_raw)
    );

    // Sign restoration on the final iteration's result
    always_comb begin
        prod_fix = job_cur.neg_lo ? (~prod_raw + 1'b1) : prod_raw;
        quo_fix  = job_cur.neg_lo ? (~quo_raw + 1'b1)  : quo_raw;
        rem_fix  = job_cur.neg_hi ? (~rem_raw + 1'b1)  : rem_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (accept && op == MD_SETHI) begin
            hi_q <= opa;
        end else if (accept && op == MD_SETLO) begin
            lo_q <= opa;
        end else if (last_w && !job_cur.zero_div) begin
            if (job_cur.kind == K_DIV) begin
                hi_q <= rem_fix;
                lo_q <= quo_fix;
            end else begin
                hi_q <= prod_fix[PW-1:XLEN];
                lo_q <= prod_fix[XLEN-1:0];
            end
        end
    end

    assign hi   = hi_q;
    assign lo   = lo_q;
    assign busy = busy_w;

    // R9: result registers frozen until the last iteration
    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_w && !last_w) |=> ($stable(hi_q) && $stable(lo_q)));

    // R6: zero-divisor run ends without touching HI/LO
    p_zero_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (last_w && job_cur.zero_div) |=> ($stable(hi_q) && $stable(lo_q)));

    // R7: moves land in one register only and never raise busy
    p_set_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_w && op == MD_SETHI) |=>
        (hi_q == $past(opa) && $stable(lo_q) && !busy_w));

    p_set_lo_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_w && op == MD_SETLO) |=>
        (lo_q == $past(opa) && $stable(hi_q) && !busy_w));

    // R11: unused codes leave everything idle
    p_unused_code_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_w && op[2:1] == 2'b11) |=>
        ($stable(hi_q) && $stable(lo_q) && !busy_w));

endmodule

// File: tb/md_unit_test.sv
`timescale 1ns/1ps
module md_unit_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    logic         busy;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] m_hi = '0;
    logic [W-1:0] m_lo = '0;

    always #2.5 clk = ~clk;

    md_unit #(.XLEN(W)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opa(opa), .opb(opb), .hi(hi), .lo(lo), .busy(busy)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference result {hi,lo} from the requirements
    function automatic logic [63:0] ref_result(input logic [2:0] c, input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic [W-1:0] h, input logic [W-1:0] l);
        longint sa, sb, sq, sr;
        logic [63:0] ua, ub, up;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (c)
            3'd0: begin sq = sa * sb; return sq; end
            3'd1: begin up = ua * ub; return up; end
            3'd2: begin
                if (b == '0) return {h, l};
                sq = sa / sb; sr = sa % sb;
                return {sr[31:0], sq[31:0]};
            end
            3'd3: begin
                if (b == '0) return {h, l};
                return {a % b, a / b};
            end
            3'd4: return {a, l};
            3'd5: return {h, b == b ? l : l};
            default: return {h, l};
        endcase
    endfunction

    task automatic run_op(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                          input string tag, input bit inject);
        logic [63:0] exp;
        int n;
        exp = ref_result(c, a, b, m_hi, m_lo);
        if (c == 3'd5) exp = {m_hi, a};
        start = 1'b1; op = c; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        if (c[2] == 1'b0) begin
            check({tag, " R8 busy rise"}, {63'd0, busy}, 64'd1);
            n = 0;
            while (busy && n < 100) begin
                n++;
                check({tag, " R9 hold"}, {hi, lo}, {m_hi, m_lo});
                if (inject && n == 5) begin
                    start = 1'b1; op = 3'd4; opa = 32'hDEAD_BEEF;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
            start = 1'b0;
            check({tag, " R8 busy length"}, 64'(n), 64'd32);
        end else begin
            check({tag, " busy low"}, {63'd0, busy}, 64'd0);
        end
        check(tag, {hi, lo}, exp);
        m_hi = exp[63:32];
        m_lo = exp[31:0];
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 hi reset", {32'd0, hi}, 64'd0);
        check("R1 lo reset", {32'd0, lo}, 64'd0);
        check("R1 busy reset", {63'd0, busy}, 64'd0);

        run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 umul max", 0);
        run_op(3'd1, 32'h0001_0000, 32'h0001_0000, "R2 umul carry", 0);
        run_op(3'd0, 32'hFFFF_FFFD, 32'd7, "R3 smul neg*pos", 0);
        run_op(3'd0, 32'h8000_0000, 32'h8000_0000, "R3 smul min*min", 0);
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 smul -1*-1", 0);
        run_op(3'd3, 32'd100, 32'd7, "R4 udiv", 0);
        run_op(3'd3, 32'hFFFF_FFFF, 32'd1, "R4 udiv by one", 0);
        run_op(3'd2, 32'hFFFF_FFF9, 32'd2, "R5 sdiv -7/2", 0);
        run_op(3'd2, 32'd7, 32'hFFFF_FFFE, "R5 sdiv 7/-2", 0);
        run_op(3'd4, 32'h1234_5678, 32'd0, "R7 set hi", 0);
        run_op(3'd5, 32'h9ABC_DEF0, 32'd0, "R7 set lo", 0);
        run_op(3'd2, 32'h5555_5555, 32'd0, "R6 sdiv by zero", 0);
        run_op(3'd3, 32'hAAAA_AAAA, 32'd0, "R6 udiv by zero", 0);
        run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R10 min/-1", 0);
        run_op(3'd6, 32'h0BAD_0BAD, 32'd3, "R11 code6", 0);
        run_op(3'd7, 32'h0BAD_0BAD, 32'd3, "R11 code7", 0);
        run_op(3'd1, 32'd123456, 32'd654321, "R9 start while busy", 1);

        for (int i = 0; i < 80; i++) begin
            logic [2:0] c;
            logic [W-1:0] a, b;
            c = 3'($urandom % 8);
            a = $urandom;
            case ($urandom % 4)
                0: b = '0;
                1: b = 32'($urandom % 16);
                2: b = 32'hFFFF_FFFF - 32'($urandom % 4);
                default: b = $urandom;
            endcase
            run_op(c, a, b, "R2-R7 random mix", (i % 9) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule